// File: doc/BRIEF.md
# Byte Queue and Transfer Counter for a Serial Bus Master

This block sits between a register interface and the bit-level shifter of a two-wire serial bus master. It owns the byte FIFO and the transfer-size counter. Together these decide, byte by byte, whether the master can keep going, has to stretch the bus, or has to signal the end of a read.

Software writes bytes when the block is sending. Each byte the shifter finishes takes the oldest one out, and the counter shows how many are still queued. When the block is receiving, software loads the counter with the number of bytes wanted. Each byte the shifter delivers is stored and lowers the count. Once a single byte remains, the block tells the shifter to answer that byte with a not-acknowledge. The hold input asks for the bus to be stretched rather than released whenever the queue cannot keep up. One-cycle event pulses report four conditions: the queue reaching its threshold, completion, overflow and underflow.

Top module: `xferFifoCtl`

## Requirements
- R1: After reset the queue is empty. In both modes `xferSize` is 0, `rxValid`, `stretch`, `nackLast` and all four event outputs are low, and `headByte` is 0.
- R2: In send mode (`rxMode`=0), an accepted `cpuPush` appends `cpuData`. `xferSize` equals the number of queued bytes, so the free space is DEPTH minus `xferSize`. `headByte` shows the oldest byte, and `busByteDone` removes it if the queue is not empty.
- R3: A byte offered while the queue holds DEPTH bytes is dropped, and `ovfEvt` pulses in the following cycle. This covers `cpuPush` in send mode and an accepted bus byte in receive mode. In receive mode the counter still decrements.
- R4: In receive mode, `sizeLoad` loads `sizeIn` (any value from 0 to 255) into the counter, and `busByteDone` is ignored in that cycle. With a nonzero count, `busByteDone` appends `busRxData` and lowers `xferSize` by one. With a count of 0, `busByteDone` has no effect.
- R5: In receive mode `nackLast` is high exactly when the count is 1. Accepting that byte brings the count to 0, and `compEvt` pulses in the next cycle, whatever `holdEn` is.
- R6: `dataEvt` pulses for one cycle after an edge that brings the fill level to DEPTH-2 from any other level.
- R7: In send mode `compEvt` pulses in the cycle after `busByteDone` removes the last queued byte with no push in the same cycle.
- R8: `stretch` is high only while `holdEn` is high. It is high in send mode when the queue is empty, and in receive mode when the queue is full and the count is nonzero.
- R9: In receive mode, `cpuPop` on an empty queue pulses `unfEvt` in the next cycle. `headByte` reads 0 whenever the queue is empty.
- R10: `clrFifo` empties the queue and zeroes its contents. It overrides every other strobe in that cycle and leaves the counter value unchanged.
- R11: `rxValid` is high exactly when the block is in receive mode and the queue is not empty. `cpuPush` is ignored in receive mode, and `cpuPop` is ignored in send mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxMode | input | 1 | 1 = receive, 0 = send |
| holdEn | input | 1 | Hold the bus instead of releasing it |
| clrFifo | input | 1 | Clear queue (pulse) |
| sizeLoad | input | 1 | Load receive count (pulse) |
| sizeIn | input | SIZE_W (8) | Receive count to load |
| cpuPush | input | 1 | Software write strobe |
| cpuData | input | DATA_W (8) | Software write byte |
| cpuPop | input | 1 | Software read strobe |
| busByteDone | input | 1 | Shifter finished one byte |
| busRxData | input | DATA_W (8) | Byte received from the bus |
| headByte | output | DATA_W (8) | Oldest queued byte, 0 when empty |
| xferSize | output | SIZE_W (8) | Queued count (send) or remaining count (receive) |
| rxValid | output | 1 | Receive data available |
| nackLast | output | 1 | Current byte is the last one; answer with not-acknowledge |
| stretch | output | 1 | Stretch the bus request |
| dataEvt | output | 1 | Threshold event pulse |
| compEvt | output | 1 | Completion event pulse |
| ovfEvt | output | 1 | Overflow event pulse |
| unfEvt | output | 1 | Underflow event pulse |

## Verification
The bench builds the block with its default values: a depth of 16 and an 8-bit counter. A full load of 255 fits in one receive run, and a few pushes are enough to reach both the threshold at 14 and the full queue. Directed sequences walk the counter down through 1 and 0, fill the queue past full in both modes, and drain it with hold set. A random phase then mixes strobes, mode changes and clears, so simultaneous push and pop at the empty and full boundaries are compared against a queue model.

// File: rtl/xferFifoPkg.sv
package xferFifoPkg;
  // Strobes from the control to the byte queue.
  typedef struct packed {
    logic push;     // append one byte
    logic pop;      // drop the oldest byte
    logic clear;    // empty and zero the queue
    logic fromBus;  // push source: 1 = bus byte, 0 = software byte
  } fifoStrobeT;
endpackage

// File: rtl/fifoDatapath.sv
module fifoDatapath
  import xferFifoPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobeT        strb,
  input  logic [DATA_W-1:0] busData,
  input  logic [DATA_W-1:0] cpuData,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic [DATA_W-1:0] headByte
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.push) begin
        mem[wrPtr] <= strb.fromBus ? busData : cpuData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (strb.pop) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(strb.push) - CNT_W'(strb.pop);
    end
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign headByte = empty ? '0 : mem[rdPtr];
endmodule

// File: rtl/xferCtrl.sv
module xferCtrl
  import xferFifoPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxMode,
  input  logic              holdEn,
  input  logic              clrFifo,
  input  logic              sizeLoad,
  input  logic [SIZE_W-1:0] sizeIn,
  input  logic              cpuPush,
  input  logic              cpuPop,
  input  logic              busByteDone,
  input  logic [CNT_W-1:0]  count,
  input  logic              full,
  input  logic              empty,
  output fifoStrobeT        strb,
  output logic [SIZE_W-1:0] xferSize,
  output logic              nackLast,
  output logic              stretch,
  output logic              rxValid,
  output logic              dataEvt,
  output logic              compEvt,
  output logic              ovfEvt,
  output logic              unfEvt
);
  localparam logic [CNT_W-1:0] THRESH = CNT_W'(DEPTH - 2);

  logic [SIZE_W-1:0] sizeReg;
  logic              acceptRx, pushReq, popReq, lastRx;
  logic [CNT_W-1:0]  nextCount;

  always_comb begin
    lastRx       = (sizeReg == SIZE_W'(1));
    acceptRx     = rxMode && busByteDone && !sizeLoad && (sizeReg != '0) && !clrFifo;
    pushReq      = rxMode ? acceptRx : (cpuPush && !clrFifo);
    popReq       = !clrFifo && (rxMode ? cpuPop : busByteDone);
    strb.push    = pushReq && !full;
    strb.pop     = popReq && !empty;
    strb.clear   = clrFifo;
    strb.fromBus = rxMode;
    nextCount    = count + CNT_W'(strb.push) - CNT_W'(strb.pop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeReg <= '0;
      dataEvt <= 1'b0;
      compEvt <= 1'b0;
      ovfEvt  <= 1'b0;
      unfEvt  <= 1'b0;
    end else begin
      if (!clrFifo && rxMode && sizeLoad) sizeReg <= sizeIn;
      else if (acceptRx)                  sizeReg <= sizeReg - SIZE_W'(1);
      dataEvt <= !clrFifo && (nextCount == THRESH) && (count != THRESH);
      compEvt <= rxMode ? (acceptRx && lastRx)
                        : (strb.pop && !strb.push && (count == CNT_W'(1)));
      ovfEvt  <= pushReq && full;
      unfEvt  <= popReq && rxMode && empty;
    end
  end

  assign xferSize = rxMode ? sizeReg : SIZE_W'(count);
  assign nackLast = rxMode && lastRx;
  assign stretch  = holdEn && (rxMode ? (full && (sizeReg != '0)) : empty);
  assign rxValid  = rxMode && !empty;
endmodule

// File: rtl/xferFifoCtl.sv
module xferFifoCtl
  import xferFifoPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxMode,
  input  logic              holdEn,
  input  logic              clrFifo,
  input  logic              sizeLoad,
  input  logic [SIZE_W-1:0] sizeIn,
  input  logic              cpuPush,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              cpuPop,
  input  logic              busByteDone,
  input  logic [DATA_W-1:0] busRxData,
  output logic [DATA_W-1:0] headByte,
  output logic [SIZE_W-1:0] xferSize,
  output logic              rxValid,
  output logic              nackLast,
  output logic              stretch,
  output logic              dataEvt,
  output logic              compEvt,
  output logic              ovfEvt,
  output logic              unfEvt
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStrobeT       strb;
  logic [CNT_W-1:0] count;
  logic             full, empty;

  xferCtrl #(.DEPTH(DEPTH), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .rxMode, .holdEn, .clrFifo, .sizeLoad, .sizeIn,
    .cpuPush, .cpuPop, .busByteDone, .count, .full, .empty,
    .strb, .xferSize, .nackLast, .stretch, .rxValid,
    .dataEvt, .compEvt, .ovfEvt, .unfEvt
  );

  fifoDatapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_data (
    .clk, .rstN, .strb, .busData(busRxData), .cpuData,
    .count, .full, .empty, .headByte
  );
endmodule

// File: rtl/xferFifoChk.sv
module xferFifoChk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxMode,
  input logic              holdEn,
  input logic              clrFifo,
  input logic              sizeLoad,
  input logic              cpuPush,
  input logic              cpuPop,
  input logic              busByteDone,
  input logic [DATA_W-1:0] headByte,
  input logic [SIZE_W-1:0] xferSize,
  input logic              rxValid,
  input logic              nackLast,
  input logic              stretch,
  input logic              compEvt,
  input logic              ovfEvt,
  input logic              unfEvt
);
  // R3: software byte offered to a full send queue is flagged
  a_r3_tx_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (!rxMode && cpuPush && !clrFifo && xferSize == SIZE_W'(DEPTH)) |=> ovfEvt);

  // R5: accepting the final counted byte completes the read
  a_r5_last_completes: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode && nackLast && busByteDone && !clrFifo && !sizeLoad) |=> compEvt);

  // R8: no stretch without hold
  a_r8_stretch_needs_hold: assert property (@(posedge clk) disable iff (!rstN)
    stretch |-> holdEn);

  // R9: read of an empty receive queue is flagged
  a_r9_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode && cpuPop && !rxValid && !clrFifo) |=> unfEvt);

  // R9: empty receive queue reads as zero
  a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode && !rxValid) |-> (headByte == '0));

  // R10: a clear leaves nothing to read
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clrFifo |=> !rxValid);
endmodule

bind xferFifoCtl xferFifoChk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/xferFifoCtl_tb.sv
`timescale 1ns/1ps
module xferFifoCtl_tb;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int SIZE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxMode = 0, holdEn = 0, clrFifo = 0, sizeLoad = 0, cpuPush = 0, cpuPop = 0, busByteDone = 0;
  logic [SIZE_W-1:0] sizeIn = '0;
  logic [DATA_W-1:0] cpuData = '0, busRxData = '0;
  logic [DATA_W-1:0] headByte;
  logic [SIZE_W-1:0] xferSize;
  logic rxValid, nackLast, stretch, dataEvt, compEvt, ovfEvt, unfEvt;

  always #2.5 clk = ~clk;

  xferFifoCtl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_dut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  int q[$];
  int mSize = 0;
  bit eData = 0, eComp = 0, eOvf = 0, eUnf = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expStretch();
    if (!holdEn) return 0;
    return rxMode ? int'(q.size() == DEPTH && mSize != 0) : int'(q.size() == 0);
  endfunction

  task automatic compareAll();
    chk("R2 R4 xferSize", int'(xferSize), rxMode ? mSize : q.size());
    chk("R11 rxValid", int'(rxValid), int'(rxMode && q.size() > 0));
    chk("R2 R9 headByte", int'(headByte), (q.size() > 0) ? q[0] : 0);
    chk("R5 nackLast", int'(nackLast), int'(rxMode && mSize == 1));
    chk("R8 stretch", int'(stretch), expStretch());
    chk("R6 dataEvt", int'(dataEvt), int'(eData));
    chk("R5 R7 compEvt", int'(compEvt), int'(eComp));
    chk("R3 ovfEvt", int'(ovfEvt), int'(eOvf));
    chk("R9 unfEvt", int'(unfEvt), int'(eUnf));
  endtask

  // One clock: drive strobes, advance the model, clock, compare at negedge.
  task automatic step(input bit push, input bit pop, input bit bus, input bit clr,
                      input bit load, input int sIn, input int cData, input int bData);
    int pre;
    bit isFull, isEmpty, pushQ, popQ, acc;
    pre = q.size();
    isFull = (pre == DEPTH);
    isEmpty = (pre == 0);
    pushQ = 0; popQ = 0;
    eData = 0; eComp = 0; eOvf = 0; eUnf = 0;
    cpuPush = push; cpuPop = pop; busByteDone = bus; clrFifo = clr; sizeLoad = load;
    sizeIn = SIZE_W'(sIn); cpuData = DATA_W'(cData); busRxData = DATA_W'(bData);
    if (clr) q.delete();
    else if (rxMode) begin
      acc = bus && !load && mSize != 0;
      if (load) mSize = sIn & 255;
      if (acc) begin
        if (isFull) eOvf = 1; else pushQ = 1;
        if (mSize == 1) eComp = 1;
        mSize = mSize - 1;
      end
      if (pop) begin
        if (isEmpty) eUnf = 1; else popQ = 1;
      end
    end else begin
      if (push) begin
        if (isFull) eOvf = 1; else pushQ = 1;
      end
      if (bus && !isEmpty) popQ = 1;
      if (popQ && !pushQ && pre == 1) eComp = 1;
    end
    if (popQ) void'(q.pop_front());
    if (pushQ) q.push_back(rxMode ? (bData & 255) : (cData & 255));
    if (!clr && q.size() == DEPTH - 2 && pre != DEPTH - 2) eData = 1;
    @(posedge clk);
    @(negedge clk);
    compareAll();
    cpuPush = 0; cpuPop = 0; busByteDone = 0; clrFifo = 0; sizeLoad = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    compareAll();
    chk("R1 xferSize after reset", int'(xferSize), 0);
    chk("R1 events after reset", int'({dataEvt, compEvt, ovfEvt, unfEvt}), 0);
    rstN = 1'b1;
    @(negedge clk);
    compareAll();

    // R2: send-mode queueing and order
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 8'hA0 + i, 0);
    chk("R2 queued count", int'(xferSize), 3);
    chk("R2 head is first", int'(headByte), 8'hA0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R2 head after bus byte", int'(headByte), 8'hA1);
    // R11: software read ignored in send mode
    step(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R11 pop ignored in send mode", int'(xferSize), 2);

    // R6 / R3: fill past the threshold and beyond full
    for (int i = 0; i < DEPTH - 2; i++) step(1, 0, 0, 0, 0, 0, i, 0);
    chk("R3 queue full", int'(xferSize), DEPTH);
    step(1, 0, 0, 0, 0, 0, 8'hEE, 0);
    chk("R3 overflow flagged", int'(ovfEvt), 1);
    chk("R3 full count kept", int'(xferSize), DEPTH);

    // R7 / R8: drain with hold
    holdEn = 1;
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R7 completion on drain", int'(compEvt), 1);
    chk("R8 stretch on empty send queue", int'(stretch), 1);
    holdEn = 0;
    @(negedge clk);
    chk("R8 no stretch without hold", int'(stretch), 0);

    // R10: clear
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 8'h55, 0);
    step(1, 0, 1, 1, 0, 0, 8'h66, 0);
    chk("R10 cleared count", int'(xferSize), 0);
    chk("R10 cleared head", int'(headByte), 0);

    // R4 / R5: receive three bytes
    rxMode = 1;
    step(0, 0, 0, 0, 1, 3, 0, 0);
    chk("R4 loaded count", int'(xferSize), 3);
    step(1, 0, 0, 0, 0, 0, 8'h77, 0);
    chk("R11 push ignored in receive mode", int'(rxValid), 0);
    step(0, 0, 1, 0, 0, 0, 0, 8'h31);
    step(0, 0, 1, 0, 0, 0, 0, 8'h32);
    chk("R5 nack on last", int'(nackLast), 1);
    step(0, 0, 1, 0, 0, 0, 0, 8'h33);
    chk("R5 completion at zero", int'(compEvt), 1);
    chk("R4 count reached zero", int'(xferSize), 0);
    step(0, 0, 1, 0, 0, 0, 0, 8'h99);
    chk("R4 byte at zero ignored", int'(xferSize), 0);
    chk("R11 rxValid", int'(rxValid), 1);
    for (int i = 0; i < 3; i++) begin
      chk("R4 stored byte", int'(headByte), 8'h31 + i);
      step(0, 1, 0, 0, 0, 0, 0, 0);
    end
    chk("R11 empty clears rxValid", int'(rxValid), 0);
    // R9: underflow
    step(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 underflow flagged", int'(unfEvt), 1);
    chk("R9 empty reads zero", int'(headByte), 0);

    // R8 / R3: receive overruns the queue
    holdEn = 1;
    step(0, 0, 0, 0, 1, 20, 0, 0);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0, 0, i);
    chk("R8 stretch on full receive queue", int'(stretch), 1);
    step(0, 0, 1, 0, 0, 0, 0, 8'hF0);
    chk("R3 receive overflow", int'(ovfEvt), 1);
    chk("R3 receive count still drops", int'(xferSize), 3);
    holdEn = 0;
    step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R10 count kept over clear", int'(xferSize), 3);

    // R4: full 255-byte load streamed through
    step(0, 0, 0, 0, 1, 255, 0, 0);
    chk("R4 max load", int'(xferSize), 255);
    for (int i = 0; i < 255; i++) step(0, 1, 1, 0, 0, 0, 0, i * 7);
    chk("R4 max load done", int'(xferSize), 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0) rxMode = $urandom % 2;
      if (i % 50 == 0) holdEn = $urandom % 2;
      step($urandom % 2, ($urandom % 3) == 0, $urandom % 2, ($urandom % 97) == 0,
           ($urandom % 40) == 0, $urandom % 40, $urandom % 256, $urandom % 256);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule